// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block derives one or more divided clocks from a single parent clock. Software writes a division ratio for each channel into a staging register; the staged value stays inert until the channel is armed with its request bit and a shared strobe bit is then raised. The armed ratio is taken up at the next divide-period boundary, so the output never shows a shortened or stretched pulse.

Each channel has an enable bit that gates its output. The gate opens and closes only at period boundaries, so every high phase that starts is completed. Supported ratios are 4, 5, 6 and 8. Odd ratios use both parent clock edges so that the high phase lasts exactly half the period. Any other ratio code selects 8.

The register port is a single-cycle write with a combinational read. Two word addresses are decoded: control at byte address 0x0 and ratio at byte address 0x8. Any other address reads zero and ignores writes.

Top module: `cdiv_top`

## Requirements
- R1: After reset, the control register reads 0 and every `div_clk` output stays low.
- R2: The control register at address 0x0 holds the following bits, and every other bit reads 0:
  - bit n (n < NUM_CH): arm request for channel n;
  - bit 8: shared commit strobe;
  - bit 24+n: enable for channel n.
- R3: The ratio register at address 0x8 holds channel n's 6-bit ratio code at bits [8n+5:8n]. Reads return the staged code, not the one in use. Every other bit reads 0.
- R4: A staged ratio does not change the output until a control write raises bit 8 from 0 to 1 while the same write sets the channel's arm bit. Staging alone, or arming alone, leaves the output period unchanged.
- R5: A commit strobe raised while a channel's arm bit is 0 does not change that channel's ratio.
- R6: Clearing the arm bits and the strobe after a commit keeps the committed ratio in use.
- R7: With ratio code 4, 5, 6 or 8 in use, the output period equals that many parent clock cycles.
- R8: The output is high for exactly half the period, counted in half parent cycles. This holds for odd ratios too.
- R9: Any ratio code other than 4, 5, 6 or 8 divides by 8.
- R10: A disabled channel's output is low. Enabling or disabling a channel takes effect only at a period boundary, so no high phase is cut short.
- R11: After reset, every channel's ratio in use and every staged code is 4. The ratio register reads 0x0404 for two channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W (4) | Byte address: 0x0 control, 0x8 ratio |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| div_clk | output | NUM_CH (2) | Divided, gated clock per channel |

## Verification
The main function is tried with every supported ratio: the even values 4, 6 and 8, and the odd value 5. Each output is sampled at every half parent cycle, so period and high time are measured separately. This shows whether the second-edge path stretches the high phase of odd ratios.

The unsupported codes 7 and 3 are each committed right after a supported code that has a different period, so a fall-through to 8 cannot be mistaken for a stale ratio. Three cases apply stimulus that must not change the output and then confirm the old period is still there:
- staging alone;
- arming alone;
- a strobe aimed only at the other channel.

A disable issued in the middle of a period confirms that every pulse seen is full length and that the line then settles low.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int REG_W        = 32;
    localparam int CNT_W        = 4;
    localparam int CODE_W       = 6;
    localparam int FIELD_STRIDE = 8;
    localparam int EN_BASE      = 24;
    localparam int STROBE_BIT   = 8;
    localparam int CTRL_ADDR    = 0;
    localparam int RATIO_ADDR   = 8;
    localparam int RESET_RATIO  = 4;

    // Map a software ratio code to the divide value actually used.
    function automatic logic [CNT_W-1:0] map_ratio(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            6'd4, 6'd5, 6'd6: r = code[CNT_W-1:0];
            default:          r = CNT_W'(8);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
    import cdiv_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata,
    output logic [NUM_CH-1:0]             ch_enable,
    output logic [NUM_CH-1:0][CODE_W-1:0] ch_code,
    output logic [NUM_CH-1:0]             ch_commit
);

    typedef struct packed {
        logic [NUM_CH-1:0]             arm;
        logic                          strobe;
        logic [NUM_CH-1:0]             en;
        logic [NUM_CH-1:0][CODE_W-1:0] stage;
    } regs_t;

    regs_t st_q, st_d;

    logic wr_ctrl, wr_ratio;
    logic unused_wdata;

    assign wr_ctrl      = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));
    assign wr_ratio     = reg_we && (reg_addr == ADDR_W'(RATIO_ADDR));
    assign unused_wdata = ^reg_wdata;

    always_comb begin
        st_d      = st_q;
        ch_commit = '0;
        if (wr_ctrl) begin
            for (int c = 0; c < NUM_CH; c++) begin
                st_d.arm[c] = reg_wdata[c];
                st_d.en[c]  = reg_wdata[EN_BASE + c];
                // commit only on a 0->1 strobe that carries this channel's arm bit
                ch_commit[c] = reg_wdata[STROBE_BIT] && !st_q.strobe && reg_wdata[c];
            end
            st_d.strobe = reg_wdata[STROBE_BIT];
        end
        if (wr_ratio) begin
            for (int c = 0; c < NUM_CH; c++) begin
                st_d.stage[c] = reg_wdata[c*FIELD_STRIDE +: CODE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.arm    <= '0;
            st_q.strobe <= 1'b0;
            st_q.en     <= '0;
            for (int c = 0; c < NUM_CH; c++) begin
                st_q.stage[c] <= CODE_W'(RESET_RATIO);
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
            for (int c = 0; c < NUM_CH; c++) begin
                reg_rdata[c]           = st_q.arm[c];
                reg_rdata[EN_BASE + c] = st_q.en[c];
            end
            reg_rdata[STROBE_BIT] = st_q.strobe;
        end else if (reg_addr == ADDR_W'(RATIO_ADDR)) begin
            for (int c = 0; c < NUM_CH; c++) begin
                reg_rdata[c*FIELD_STRIDE +: CODE_W] = st_q.stage[c];
            end
        end
    end

    assign ch_enable = st_q.en;
    assign ch_code   = st_q.stage;

endmodule

// File: rtl/cdiv_chan.sv
module cdiv_chan
    import cdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              commit,
    input  logic [CODE_W-1:0] code,
    output logic              clk_out,
    output logic [CNT_W-1:0]  ratio_now,
    output logic [CNT_W-1:0]  phase,
    output logic              running
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ratio;
        logic             run;
        logic             pend;
        logic [CNT_W-1:0] pend_ratio;
        logic             pos;
    } chan_t;

    chan_t st_q, st_d;
    logic  neg_q;
    logic  last;

    assign last = (st_q.cnt == st_q.ratio - CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.pend       = 1'b1;
            st_d.pend_ratio = map_ratio(code);
        end
        if (last) begin
            // period boundary: adopt pending ratio and gate state together
            st_d.cnt = '0;
            st_d.run = enable;
            if (st_d.pend) begin
                st_d.ratio = st_d.pend_ratio;
            end
            st_d.pend = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.pos = st_d.run && (st_d.cnt < (st_d.ratio >> 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt        <= '0;
            st_q.ratio      <= CNT_W'(RESET_RATIO);
            st_q.run        <= 1'b0;
            st_q.pend       <= 1'b0;
            st_q.pend_ratio <= CNT_W'(RESET_RATIO);
            st_q.pos        <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // half-cycle delayed copy stretches the high phase of odd ratios
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= st_q.pos;
        end
    end

    assign clk_out   = st_q.pos | (st_q.ratio[0] & neg_q);
    assign ratio_now = st_q.ratio;
    assign phase     = st_q.cnt;
    assign running   = st_q.run;

endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
    import cdiv_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] div_clk
);

    logic [NUM_CH-1:0]             ch_enable;
    logic [NUM_CH-1:0][CODE_W-1:0] ch_code;
    logic [NUM_CH-1:0]             ch_commit;
    logic [NUM_CH-1:0][CNT_W-1:0]  act_ratio;
    logic [NUM_CH-1:0][CNT_W-1:0]  chan_cnt;
    logic [NUM_CH-1:0]             chan_run;

    cdiv_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ch_enable (ch_enable),
        .ch_code   (ch_code),
        .ch_commit (ch_commit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cdiv_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (ch_enable[c]),
            .commit    (ch_commit[c]),
            .code      (ch_code[c]),
            .clk_out   (div_clk[c]),
            .ratio_now (act_ratio[c]),
            .phase     (chan_cnt[c]),
            .running   (chan_run[c])
        );
    end

endmodule

// File: rtl/cdiv_top_chk.sv
module cdiv_top_chk #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [31:0]             reg_rdata,
    input logic [NUM_CH-1:0]       div_clk,
    input logic [NUM_CH-1:0][3:0]  act_ratio,
    input logic [NUM_CH-1:0][3:0]  chan_cnt,
    input logic [NUM_CH-1:0]       chan_run
);

    localparam logic [31:0] CTRL_MASK =
        (((32'd1 << NUM_CH) - 32'd1) << 24) | 32'h100 | ((32'd1 << NUM_CH) - 32'd1);

    assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> ((reg_rdata & ~CTRL_MASK) == 32'd0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_ratio_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (act_ratio[c] == 4'd4) || (act_ratio[c] == 4'd5) ||
            (act_ratio[c] == 4'd6) || (act_ratio[c] == 4'd8));

        assert_switch_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(act_ratio[c]) |-> (chan_cnt[c] == 4'd0));

        assert_phase_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
            chan_cnt[c] < act_ratio[c]);

        assert_gated_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_run[c] |-> !div_clk[c]);

        assert_reset_ratio_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (act_ratio[c] == 4'd4));
    end

endmodule

bind cdiv_top cdiv_top_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .div_clk   (div_clk),
    .act_ratio (act_ratio),
    .chan_cnt  (chan_cnt),
    .chan_run  (chan_run)
);

// File: tb/cdiv_top_test.sv
module cdiv_top_test;

    localparam int NUM_CH = 2;
    localparam logic [31:0] EN0 = 32'h0100_0000;
    localparam logic [31:0] EN1 = 32'h0200_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NUM_CH-1:0] div_clk;

    always #10 clk = ~clk;

    cdiv_top #(.NUM_CH(NUM_CH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .div_clk   (div_clk)
    );

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    typedef struct {
        int    ch;
        int    ratio;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    bit   mon_busy = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic half_sample(input int ch, output logic v);
        @(posedge clk or negedge clk);
        #5 v = div_clk[ch];
    endtask

    // monitor: measure one full period per expected item
    initial begin
        forever begin
            exp_t e;
            logic v, prev;
            int   h, l;
            bit   found;
            wait (sb_q.size() > 0);
            mon_busy = 1'b1;
            e = sb_q.pop_front();
            prev = 1'b1; found = 1'b0; h = 0; l = 0;
            for (int i = 0; i < 100; i++) begin
                half_sample(e.ch, v);
                if (!prev && v) begin found = 1'b1; break; end
                prev = v;
            end
            if (found) begin
                h = 1;
                for (int i = 0; i < 100; i++) begin
                    half_sample(e.ch, v);
                    if (v) h++; else break;
                end
                l = 1;
                for (int i = 0; i < 100; i++) begin
                    half_sample(e.ch, v);
                    if (!v) l++; else break;
                end
            end
            chk({e.tag, " R7 period in half cycles"}, 32'(h + l), 32'(2 * e.ratio));
            chk({e.tag, " R8 high half cycles"},      32'(h),     32'(e.ratio));
            mon_busy = 1'b0;
        end
    end

    task automatic expect_rate(input int ch, input int ratio, input string tag);
        exp_t e;
        e.ch = ch; e.ratio = ratio; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
        wait (mon_busy == 1'b0);
    endtask

    task automatic commit(input logic [31:0] en, input logic [31:0] arm);
        wr(4'h0, en | arm);
        wr(4'h0, en | arm | 32'h100);
        wr(4'h0, en);
        repeat (20) @(posedge clk);
    endtask

    task automatic settle();
        repeat (20) @(posedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        v;
        int          lows;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R11: reset state
        rd(4'h0, d); chk("R1 control after reset", d, 32'h0);
        rd(4'h8, d); chk("R11 staged ratio after reset", d, 32'h0000_0404);
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            half_sample(0, v); if (!v) lows++;
            half_sample(1, v); if (!v) lows++;
        end
        chk("R1 outputs low after reset", 32'(lows), 32'd80);

        // R2 / R3: layout and reserved bits
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R2 control readback", d, 32'h0300_0103);
        wr(4'h0, 32'h0);
        rd(4'h0, d); chk("R2 control cleared", d, 32'h0);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, d); chk("R3 ratio readback", d, 32'h0000_3F3F);
        wr(4'h8, 32'h0000_0404);
        rd(4'h4, d); chk("R3 unmapped address reads zero", d, 32'h0);

        // R11 / R10: enable ch0 with default ratio
        wr(4'h0, EN0);
        settle();
        expect_rate(0, 4, "R11 default ratio");

        // R4: staging alone, then arming alone, do not take effect
        wr(4'h8, 32'h0000_0405);
        rd(4'h8, d); chk("R3 staged readback", d, 32'h0000_0405);
        settle();
        expect_rate(0, 4, "R4 staged only");
        wr(4'h0, EN0 | 32'h1);
        settle();
        expect_rate(0, 4, "R4 armed without strobe");
        wr(4'h0, EN0 | 32'h101);
        settle();
        expect_rate(0, 5, "R4 committed odd ratio");
        wr(4'h0, EN0);
        settle();
        expect_rate(0, 5, "R6 after clearing arm and strobe");

        // R7 / R8: even ratios
        wr(4'h8, 32'h0000_0406); commit(EN0, 32'h1);
        expect_rate(0, 6, "R7 ratio 6");
        wr(4'h8, 32'h0000_0408); commit(EN0, 32'h1);
        expect_rate(0, 8, "R7 ratio 8");

        // R9: unsupported codes
        wr(4'h8, 32'h0000_0405); commit(EN0, 32'h1);
        expect_rate(0, 5, "R9 setup ratio 5");
        wr(4'h8, 32'h0000_0407); commit(EN0, 32'h1);
        expect_rate(0, 8, "R9 code 7");
        wr(4'h8, 32'h0000_0404); commit(EN0, 32'h1);
        wr(4'h8, 32'h0000_0403); commit(EN0, 32'h1);
        expect_rate(0, 8, "R9 code 3");

        // R5: strobe aimed at ch1 only
        wr(4'h8, 32'h0000_0604);
        commit(EN0 | EN1, 32'h2);
        expect_rate(1, 6, "R5 targeted channel");
        expect_rate(0, 8, "R5 untargeted channel");

        // R10: disable ch1 in mid-period
        begin
            logic smp [0:99];
            int   run_len, bad, tail_low;
            bit   in_run, seen_low;
            fork
                begin
                    for (int i = 0; i < 100; i++) half_sample(1, smp[i]);
                end
                begin
                    repeat (13) @(posedge clk);
                    #3;
                    wr(4'h0, EN0);
                end
            join
            bad = 0; run_len = 0; in_run = 1'b0; seen_low = 1'b0;
            for (int i = 0; i < 100; i++) begin
                if (smp[i]) begin
                    if (seen_low) begin in_run = 1'b1; run_len++; end
                end else begin
                    if (in_run && run_len != 6) bad++;
                    in_run = 1'b0; run_len = 0; seen_low = 1'b1;
                end
            end
            chk("R10 no truncated pulse on disable", 32'(bad), 32'd0);
            tail_low = 0;
            for (int i = 70; i < 100; i++) if (!smp[i]) tail_low++;
            chk("R10 output low after disable", 32'(tail_low), 32'd30);
        end
        wr(4'h0, EN0 | EN1);
        settle();
        expect_rate(1, 6, "R10 re-enable full pulse");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule